// File: doc/BRIEF.md
# Command Ring Buffer Controller

This block manages a circular command buffer of 4096 bytes. The buffer sits between a host that produces commands and an engine that consumes them. The host stores 32-bit command words in the buffer storage through a byte-addressed write port. It then publishes a new write pointer. Whenever the read pointer differs from the write pointer, the controller presents the word at the read pointer to the consumer over a valid/ready handshake. Each accepted word moves the read pointer forward by one word, and streaming stops when the read pointer catches up with the write pointer.

Both pointers are byte offsets that wrap modulo the buffer size. One word slot always stays unused, so a completely filled buffer can never be mistaken for an empty one. The controller reports both pointers and the number of free bytes. It refuses any publish that would move the write pointer further than the free space allows, and it records each refusal in a sticky flag. Command meaning and argument layout are left to the consumer.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset the read pointer and the write pointer are 0, busy and cmd_valid are low, overflow is low and free_bytes is 4092.
- R2: A storage write puts mem_wdata into the word slot selected by mem_addr with bits [1:0] ignored, so byte addresses 4k to 4k+3 all reach the same word.
- R3: busy and cmd_valid are high exactly when the read and write pointers differ, and cmd_data then holds the word stored at the read pointer.
- R4: The read pointer advances by 4 in the cycle after cmd_valid and cmd_ready are both high, and it stays put in every other cycle. An advance from 4092 wraps to 0.
- R5: A published write pointer has bits [1:0] cleared before it is used.
- R6: free_bytes equals 4092 minus ((write pointer − read pointer) mod 4096).
- R7: A publish whose forward distance ((new − current write pointer) mod 4096) exceeds free_bytes leaves the write pointer unchanged and sets overflow. Overflow stays high until reset. A publish whose distance is no more than free_bytes is accepted, and this includes a distance of 0.
- R8: The write pointer wraps modulo 4096, so publishing a value below the current write pointer means a forward move across the end of the buffer.
- R9: While cmd_valid is high and cmd_ready is low, cmd_data and the read pointer stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_we | input | 1 | Storage write strobe from the host |
| mem_addr | input | 12 | Byte address of the storage write |
| mem_wdata | input | 32 | Word to store |
| wp_we | input | 1 | Publish strobe for a new write pointer |
| wp_data | input | 12 | Proposed write pointer (byte offset) |
| cmd_valid | output | 1 | A word is offered to the consumer |
| cmd_ready | input | 1 | Consumer accepts the offered word |
| cmd_data | output | 32 | Word at the read pointer |
| rd_ptr | output | 12 | Current read pointer |
| wr_ptr | output | 12 | Current write pointer |
| free_bytes | output | 12 | Bytes available to the host |
| busy | output | 1 | Pointers differ |
| overflow | output | 1 | Sticky flag for a refused publish |

## Verification
Publishes are tried with several input patterns: a short aligned burst that is consumed only in part, a misaligned value that must round down onto the current pointer, a large forward jump that leaves little room, a publish that crosses the end of the buffer, a publish that oversteps the free space, and a publish that fills the buffer exactly. Together these separate correct modular distance and free-space arithmetic from naive subtraction, and an exact-fit acceptance from an off-by-one refusal. A drain of 1023 words checks every word against its stored value across the read wraparound. A stalled consumer shows whether the handshake holds its data. A misaligned storage write shows whether the address bits [1:0] are ignored.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = 32;
  typedef logic [WORD_W-1:0] cmd_word_t;
endpackage

// File: rtl/cmdring_mem.sv
module cmdring_mem
  import cmdring_pkg::*;
#(
  parameter int unsigned PTR_W = 12
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_byte_addr,
  input  cmd_word_t        wr_word,
  input  logic [PTR_W-1:0] rd_byte_addr,
  output cmd_word_t        rd_word
);
  localparam int unsigned SLOT_W = PTR_W - 2;
  localparam int unsigned SLOTS  = 1 << SLOT_W;

  cmd_word_t store_q [SLOTS];

  wire [SLOT_W-1:0] wr_slot = wr_byte_addr[PTR_W-1:2];
  wire [SLOT_W-1:0] rd_slot = rd_byte_addr[PTR_W-1:2];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_slot] <= wr_word;
  end

  assign rd_word = store_q[rd_slot];
endmodule

// File: rtl/cmdring_wptr.sv
module cmdring_wptr #(
  parameter int unsigned PTR_W     = 12,
  parameter int unsigned BUF_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pub_we,
  input  logic [PTR_W-1:0] pub_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] free_bytes,
  output logic             overflow,
  output logic             accept_evt,
  output logic             reject_evt
);
  localparam logic [PTR_W-1:0] USABLE = PTR_W'(BUF_BYTES - cmdring_pkg::WORD_BYTES);

  // forward distance from a to b on the ring
  function automatic logic [PTR_W-1:0] ring_dist(input logic [PTR_W-1:0] a,
                                                 input logic [PTR_W-1:0] b);
    return b - a;
  endfunction

  function automatic logic [PTR_W-1:0] align_down(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:2], 2'b00};
  endfunction

  logic [PTR_W-1:0] wp_q;
  logic             ovf_q;
  logic [PTR_W-1:0] cand;
  logic [PTR_W-1:0] step;

  assign free_bytes = USABLE - ring_dist(rd_ptr, wp_q);
  assign cand       = align_down(pub_ptr);
  assign step       = ring_dist(wp_q, cand);
  assign accept_evt = pub_we && (step <= free_bytes);
  assign reject_evt = pub_we && (step >  free_bytes);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (accept_evt) wp_q <= cand;
      if (reject_evt) ovf_q <= 1'b1;
    end
  end

  assign wr_ptr   = wp_q;
  assign overflow = ovf_q;

  a_r7_wp_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wp_q) |-> $past(accept_evt));
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r7_reject_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (ovf_q && $stable(wp_q)));
endmodule

// File: rtl/cmdring_rptr.sv
module cmdring_rptr #(
  parameter int unsigned PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             take,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             pending,
  output logic             fire_evt
);
  function automatic logic [PTR_W-1:0] next_word(input logic [PTR_W-1:0] p);
    return p + PTR_W'(cmdring_pkg::WORD_BYTES);
  endfunction

  logic [PTR_W-1:0] rp_q;

  assign pending  = (rp_q != wr_ptr);
  assign fire_evt = pending && take;

  always_ff @(posedge clk) begin
    if (!rst_n)        rp_q <= '0;
    else if (fire_evt) rp_q <= next_word(rp_q);
  end

  assign rd_ptr = rp_q;

  a_r4_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rp_q) |-> (rp_q == PTR_W'($past(rp_q) + 4)));
  a_r4_moves_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rp_q) |-> $past(fire_evt));
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> $stable(rp_q));
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmdring_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 4096,
  parameter int unsigned PTR_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_we,
  input  logic [PTR_W-1:0] mem_addr,
  input  logic [31:0]      mem_wdata,
  input  logic             wp_we,
  input  logic [PTR_W-1:0] wp_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [31:0]      cmd_data,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] free_bytes,
  output logic             busy,
  output logic             overflow
);
  logic [PTR_W-1:0] rp_w;
  logic [PTR_W-1:0] wp_w;
  logic             pending_w;
  logic             fire_evt;
  logic             accept_evt;
  logic             reject_evt;
  cmd_word_t        rd_word_w;

  cmdring_mem #(.PTR_W(PTR_W)) u_mem (
    .clk          (clk),
    .wr_en        (mem_we),
    .wr_byte_addr (mem_addr),
    .wr_word      (mem_wdata),
    .rd_byte_addr (rp_w),
    .rd_word      (rd_word_w)
  );

  cmdring_wptr #(.PTR_W(PTR_W), .BUF_BYTES(BUF_BYTES)) u_wptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pub_we     (wp_we),
    .pub_ptr    (wp_data),
    .rd_ptr     (rp_w),
    .wr_ptr     (wp_w),
    .free_bytes (free_bytes),
    .overflow   (overflow),
    .accept_evt (accept_evt),
    .reject_evt (reject_evt)
  );

  cmdring_rptr #(.PTR_W(PTR_W)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ptr   (wp_w),
    .take     (cmd_ready),
    .rd_ptr   (rp_w),
    .pending  (pending_w),
    .fire_evt (fire_evt)
  );

  assign cmd_valid = pending_w;
  assign busy      = pending_w;
  assign cmd_data  = rd_word_w;
  assign rd_ptr    = rp_w;
  assign wr_ptr    = wp_w;

  a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !mem_we) |=> $stable(cmd_data));
  a_r7_no_dual_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_evt && reject_evt));
endmodule

// File: tb/tb_cmd_ring_ctrl.sv
module tb_cmd_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_we = 1'b0;
  logic [11:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic        wp_we = 1'b0;
  logic [11:0] wp_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic [11:0] rd_ptr, wr_ptr, free_bytes;
  logic        busy, overflow;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  cmd_ring_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wp_we(wp_we), .wp_data(wp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .free_bytes(free_bytes),
    .busy(busy), .overflow(overflow)
  );

  typedef struct packed {
    logic [11:0] pub;
    logic [11:0] n_take;
    logic [11:0] exp_rp;
    logic [11:0] exp_wp;
    logic [11:0] exp_free;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{12'd16,   12'd2,    12'd8,  12'd16,   12'd4084, 1'b0},
    '{12'd19,   12'd2,    12'd16, 12'd16,   12'd4092, 1'b0},
    '{12'd4000, 12'd0,    12'd16, 12'd4000, 12'd108,  1'b0},
    '{12'd8,    12'd0,    12'd16, 12'd8,    12'd4,    1'b0},
    '{12'd16,   12'd0,    12'd16, 12'd8,    12'd4,    1'b1},
    '{12'd12,   12'd0,    12'd16, 12'd12,   12'd0,    1'b1},
    '{12'd12,   12'd1023, 12'd12, 12'd12,   12'd4092, 1'b1}
  };

  function automatic logic [31:0] pattern(input int slot);
    return (32'(slot) * 32'h0101_0101) ^ 32'h5A00_00C3;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic publish(input logic [11:0] p);
    @(negedge clk) begin wp_we = 1'b1; wp_data = p; end
    @(negedge clk) wp_we = 1'b0;
  endtask

  task automatic consume(input int n, inout logic [11:0] rp);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R3 valid", 32'(cmd_valid), 32'd1);
      check("R3 data", cmd_data, pattern(int'(rp >> 2)));
      cmd_ready = 1'b1;
      @(posedge clk);
      rp = rp + 12'd4;
    end
    @(negedge clk) cmd_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] rp_m;
    logic [31:0] held;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 rd_ptr", 32'(rd_ptr), 0);
    check("R1 wr_ptr", 32'(wr_ptr), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 valid", 32'(cmd_valid), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 free", 32'(free_bytes), 4092);

    // fill storage with a known pattern (R2)
    for (int s = 0; s < 1024; s++) begin
      @(negedge clk) begin mem_we = 1'b1; mem_addr = 12'(s * 4); mem_wdata = pattern(s); end
    end
    @(negedge clk) mem_we = 1'b0;

    rp_m = '0;
    for (int i = 0; i < 7; i++) begin
      publish(VECS[i].pub);
      consume(int'(VECS[i].n_take), rp_m);
      @(negedge clk);
      check("R4 rd_ptr", 32'(rd_ptr), 32'(VECS[i].exp_rp));
      check("R5/R7/R8 wr_ptr", 32'(wr_ptr), 32'(VECS[i].exp_wp));
      check("R6 free", 32'(free_bytes), 32'(VECS[i].exp_free));
      check("R7 overflow", 32'(overflow), 32'(VECS[i].exp_ovf));
      check("R3 busy", 32'(busy), 32'(VECS[i].exp_rp != VECS[i].exp_wp));
    end

    // R9 stall: one word pending, ready low
    publish(12'd16);
    @(negedge clk);
    held = cmd_data;
    check("R9 data at rp", held, pattern(3));
    repeat (3) @(negedge clk);
    check("R9 data held", cmd_data, held);
    check("R9 rp held", 32'(rd_ptr), 12);
    check("R3 valid while pending", 32'(cmd_valid), 1);

    // R1/R7 overflow cleared only by reset
    do_reset();
    @(negedge clk);
    check("R7 overflow cleared by reset", 32'(overflow), 0);
    check("R1 rd_ptr after reset", 32'(rd_ptr), 0);

    // R2 misaligned storage write lands in slot 1
    @(negedge clk) begin mem_we = 1'b1; mem_addr = 12'd7; mem_wdata = 32'hFEED_0007; end
    @(negedge clk) mem_we = 1'b0;
    publish(12'd8);
    @(negedge clk);
    check("R2 slot0 untouched", cmd_data, pattern(0));
    @(negedge clk) cmd_ready = 1'b1;
    @(negedge clk) cmd_ready = 1'b0;
    check("R2 misaligned write", cmd_data, 32'hFEED_0007);
    check("R4 one step", 32'(rd_ptr), 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule